// File: doc/BRIEF.md
# Three-Axis Sample Freshness Tracker

This block sits between a three-axis sensing front end and the register file a host reads. For each axis, the front end pulses a completion strobe and presents a 16-bit sample. The block latches that sample and raises a per-axis fresh flag. When a second sample arrives on an axis before the host has fetched the first, the block also raises a per-axis overrun flag.

Two further flags cover the three axes together. One shows that a complete X/Y/Z set is waiting. The other shows that a complete set was replaced before the host had finished reading the one before it.

The host reads through a simple strobe-plus-address port, with combinational read data:
- Address 0 returns the status byte.
- Addresses 1 to 6 return the sample bytes.
- Reading the high byte of an axis is what marks that axis as fetched.

Top module: `axis_ready_tracker`

## Requirements
- R1: The status byte is {all_overrun, Z_overrun, Y_overrun, X_overrun, all_fresh, Z_fresh, Y_fresh, X_fresh}, bit 7 down to bit 0, and is visible both on `status` and at read address 0.
- R2: A completion strobe on an axis sets that axis's fresh flag on the next clock edge.
- R3: A read strobe at an axis's high-byte address (1 for X, 3 for Y, 5 for Z) clears that axis's fresh flag on the next edge. Reads at low-byte addresses (2, 4, 6) or at any other address change no flag.
- R4: A completion strobe on an axis whose fresh flag is set, with no high-byte read of that axis in the same cycle, sets that axis's overrun flag.
- R5: The high-byte read that clears an axis's fresh flag also clears its overrun flag.
- R6: When a completion strobe and a high-byte read hit the same axis in one cycle, the fresh flag ends up set and the overrun flag ends up cleared.
- R7: The all-fresh flag sets on the edge where each axis has completed at least once since the previous set was formed. Forming a set restarts that collection. The flag clears once the high bytes of all three axes have been read after the set was formed.
- R8: The all-overrun flag sets when a new full set forms while the all-fresh flag is set and the previous set has not been fully read. It clears together with the all-fresh flag.
- R9: On a completion strobe, the axis sample is latched. Read data is combinational: address 1+2k returns sample k bits 15:8, address 2+2k returns sample k bits 7:0 (k = 0 X, 1 Y, 2 Z), and addresses 7 and above return 0.
- R10: With `rst_n` low at a clock edge, all flags, set-tracking state and samples are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_done | input | 3 | Per-axis completion strobe, bit 0 X |
| acq_sample | input | 48 | New samples, X in bits 15:0, Y in 31:16, Z in 47:32 |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Read data for the current address |
| status | output | 8 | Status byte |

## Verification
The bench drives several same-cycle collisions, each aimed at a specific fault:
- A completion and a high-byte read on the same axis; a design that gave the read priority would drop fresh data.
- A second completion on an axis before its high byte is read; a design without that check would miss the overrun.
- A low-byte read; a design that cleared flags on it would lose flags the host had not fetched.

For the combined flags, the bench reads axes one at a time and checks that all-fresh holds until the last of the three high bytes is read. It also forms a second full set before the first is read and checks that all-overrun rises. A design that cleared the combined flag on the first read, or never set it, shows a mismatch.

A long random run compares every status byte and read byte against a behavioural model. A mid-run reset checks that everything returns to zero.

// File: rtl/axtrk_pkg.sv
// Shared sizing for the three-axis freshness tracker.
package axtrk_pkg;
    parameter int unsigned NUM_AXES  = 3;
    parameter int unsigned SAMPLE_W  = 16;
    parameter int unsigned ADDR_W    = 8;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned BYTES_PER_AXIS = SAMPLE_W / BYTE_W;
    localparam int unsigned STAT_W   = 2 * NUM_AXES + 2;
endpackage

// File: rtl/axtrk_axis_slot.sv
// One axis: holds the latest sample, a fresh flag and an overrun flag.
// Assumes acq and msb_rd are single-cycle strobes; a completion wins
// over a read in the same cycle so new data is never discarded.
module axtrk_axis_slot #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acq,
    input  logic [W-1:0] acq_data,
    input  logic         msb_rd,
    output logic         fresh,
    output logic         overrun,
    output logic [W-1:0] sample
);
    // Sample capture on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)   sample <= '0;
        else if (acq) sample <= acq_data;
    end

    // Fresh/overrun flag update with set priority over read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            fresh   <= acq | (fresh & ~msb_rd);
            overrun <= ~msb_rd & (overrun | (acq & fresh));
        end
    end

    a_r2_fresh_sets: assert property (@(posedge clk) disable iff (!rst_n)
        acq |=> fresh);
    a_r3_fresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (msb_rd && !acq) |=> !fresh);
    a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (acq && fresh && !msb_rd) |=> overrun);
    a_r6_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (acq && msb_rd) |=> (fresh && !overrun));
endmodule

// File: rtl/axtrk_set_tracker.sv
// Combined flags across all axes. A set forms once each axis has completed
// since the last set; it counts as consumed when every axis high byte
// has been read after forming. Assumes per-axis strobes as in the slots.
module axtrk_set_tracker #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] acq,
    input  logic [N-1:0] msb_rd,
    output logic         all_fresh,
    output logic         all_overrun
);
    logic [N-1:0] seen, unread;
    logic [N-1:0] seen_nxt, remaining;
    logic         set_forms, drained;

    // Next-state helpers for collection and readout.
    always_comb begin
        seen_nxt  = seen | acq;
        set_forms = &seen_nxt;
        remaining = unread & ~msb_rd;
        drained   = all_fresh && (remaining == '0);
    end

    // Collection of completions and readout of the current set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen        <= '0;
            unread      <= '0;
            all_fresh   <= 1'b0;
            all_overrun <= 1'b0;
        end else if (set_forms) begin
            seen        <= '0;
            unread      <= '1;
            all_fresh   <= 1'b1;
            all_overrun <= all_fresh && (remaining != '0);
        end else begin
            seen        <= seen_nxt;
            unread      <= remaining;
            if (drained) begin
                all_fresh   <= 1'b0;
                all_overrun <= 1'b0;
            end
        end
    end

    a_r8_overrun_needs_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        all_overrun |-> all_fresh);
    a_r7_set_forms: assert property (@(posedge clk) disable iff (!rst_n)
        set_forms |=> (all_fresh && unread == '1));
endmodule

// File: rtl/axtrk_read_mux.sv
// Read port decode: address 0 gives status, then high/low bytes of each
// axis in axis order. Purely combinational; unmapped addresses give zero.
module axtrk_read_mux #(
    parameter int unsigned N      = 3,
    parameter int unsigned W      = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned STAT_W = 8
) (
    input  logic [STAT_W-1:0] status,
    input  logic [N*W-1:0]    samples,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int unsigned BPA = W / 8;

    // Address decode to byte.
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = 8'(status);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < BPA; j++) begin
                if (rd_addr == ADDR_W'(1 + i * BPA + j))
                    rd_data = samples[i*W + W - 1 - 8*j -: 8];
            end
        end
    end
endmodule

// File: rtl/axis_ready_tracker.sv
// Top: per-axis slots, combined-set tracker and read decode.
// Assumes host reads are one-cycle strobes; a high-byte read clears flags.
module axis_ready_tracker
    import axtrk_pkg::*;
#(
    parameter int unsigned N      = NUM_AXES,
    parameter int unsigned W      = SAMPLE_W,
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned SW     = 2 * N + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  acq_done,
    input  logic [N*W-1:0] acq_sample,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [SW-1:0] status
);
    localparam int unsigned BPA = W / 8;

    logic [N-1:0]   msb_rd, fresh, overrun;
    logic [N*W-1:0] samples;
    logic           all_fresh, all_overrun;

    for (genvar i = 0; i < N; i++) begin : g_axis
        assign msb_rd[i] = rd_en && (rd_addr == AW'(1 + i * BPA));
        axtrk_axis_slot #(.W(W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .acq(acq_done[i]), .acq_data(acq_sample[i*W +: W]),
            .msb_rd(msb_rd[i]),
            .fresh(fresh[i]), .overrun(overrun[i]),
            .sample(samples[i*W +: W])
        );
    end

    axtrk_set_tracker #(.N(N)) u_set (
        .clk(clk), .rst_n(rst_n),
        .acq(acq_done), .msb_rd(msb_rd),
        .all_fresh(all_fresh), .all_overrun(all_overrun)
    );

    assign status = {all_overrun, overrun, all_fresh, fresh};

    axtrk_read_mux #(.N(N), .W(W), .ADDR_W(AW), .STAT_W(SW)) u_mux (
        .status(status), .samples(samples), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    a_r1_combined_fresh_vs_axes: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_done == '1) |=> (status[N] && (fresh == '1)));
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status == '0));
endmodule

// File: tb/axis_ready_tracker_test.sv
module axis_ready_tracker_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  acq_done = 0;
    logic [47:0] acq_sample = 0;
    logic        rd_en = 0;
    logic [7:0]  rd_addr = 0;
    logic [7:0]  rd_data, status;

    int checks = 0, failures = 0;
    bit done = 0;
    string tag = "R10";

    int m_fr[3], m_ov[3], m_seen[3], m_unread[3], m_smp[3];
    int m_af = 0, m_ao = 0;

    always #4 clk = ~clk;

    axis_ready_tracker uut (.clk(clk), .rst_n(rst_n), .acq_done(acq_done),
        .acq_sample(acq_sample), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status));

    function automatic int exp_status();
        return m_fr[0] | m_fr[1] << 1 | m_fr[2] << 2 | m_af << 3 |
               m_ov[0] << 4 | m_ov[1] << 5 | m_ov[2] << 6 | m_ao << 7;
    endfunction

    function automatic int exp_rd(int a);
        if (a == 0) return exp_status();
        if (a >= 1 && a <= 6) begin
            int k = (a - 1) / 2;
            return (a % 2 == 1) ? (m_smp[k] >> 8) & 255 : m_smp[k] & 255;
        end
        return 0;
    endfunction

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int rd[3];
        int all_seen = 1, rem_any = 0;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_fr[i] = 0; m_ov[i] = 0; m_seen[i] = 0; m_unread[i] = 0; m_smp[i] = 0;
            end
            m_af = 0; m_ao = 0;
            return;
        end
        for (int i = 0; i < 3; i++) begin
            rd[i] = (rd_en && rd_addr == 1 + 2 * i) ? 1 : 0;
            if (!(m_seen[i] || acq_done[i])) all_seen = 0;
            if (m_unread[i] && !rd[i]) rem_any = 1;
        end
        for (int i = 0; i < 3; i++) begin
            if (acq_done[i]) begin
                m_ov[i] = (m_fr[i] && !rd[i]) || (m_ov[i] && !rd[i]);
                m_fr[i] = 1;
                m_smp[i] = int'(acq_sample[16*i +: 16]);
            end else if (rd[i]) begin
                m_fr[i] = 0; m_ov[i] = 0;
            end
        end
        if (all_seen) begin
            m_ao = (m_af && rem_any) ? 1 : 0;
            m_af = 1;
            for (int i = 0; i < 3; i++) begin m_seen[i] = 0; m_unread[i] = 1; end
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (acq_done[i]) m_seen[i] = 1;
                if (rd[i]) m_unread[i] = 0;
            end
            if (m_af && !rem_any) begin m_af = 0; m_ao = 0; end
        end
    endtask

    task automatic cyc(bit rn, logic [2:0] acq, logic [47:0] d, bit re, logic [7:0] a);
        rst_n = rn; acq_done = acq; acq_sample = d; rd_en = re; rd_addr = a;
        #1;
        check("status", status, exp_status());
        check("rd_data", rd_data, exp_rd(a));
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R10";
        repeat (3) cyc(0, 3'b111, 48'h1111_2222_3333, 0, 0);
        tag = "R2";
        cyc(1, 3'b001, 48'h1234, 0, 0);
        tag = "R9";
        cyc(1, 0, 0, 0, 1);
        tag = "R3";
        cyc(1, 0, 0, 1, 2);
        cyc(1, 0, 0, 1, 9);
        cyc(1, 0, 0, 1, 1);
        cyc(1, 0, 0, 0, 0);
        tag = "R4";
        cyc(1, 3'b010, 48'h00AA_0000, 0, 0);
        cyc(1, 3'b010, 48'h00BB_0000, 0, 0);
        cyc(1, 0, 0, 0, 0);
        tag = "R5";
        cyc(1, 0, 0, 1, 3);
        cyc(1, 0, 0, 0, 0);
        tag = "R6";
        cyc(1, 3'b100, 48'h5678_0000_0000, 0, 0);
        cyc(1, 3'b100, 48'h9ABC_0000_0000, 1, 5);
        cyc(1, 0, 0, 0, 5);
        cyc(1, 0, 0, 1, 5);
        tag = "R7";
        cyc(1, 3'b011, 48'h0003_0002_0001, 0, 0);
        cyc(1, 3'b100, 48'h0007_0000_0000, 0, 0);
        cyc(1, 0, 0, 1, 1);
        cyc(1, 0, 0, 1, 3);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, 5);
        cyc(1, 0, 0, 0, 0);
        tag = "R8";
        cyc(1, 3'b111, 48'h0C0C_0B0B_0A0A, 0, 0);
        cyc(1, 0, 0, 1, 1);
        cyc(1, 3'b111, 48'hF00D_BEEF_CAFE, 0, 0);
        cyc(1, 0, 0, 1, 1);
        cyc(1, 0, 0, 1, 3);
        cyc(1, 0, 0, 1, 5);
        cyc(1, 0, 0, 0, 0);
        tag = "R9";
        for (int a = 0; a < 10; a++) cyc(1, 0, 0, 0, 8'(a));
        cyc(1, 0, 0, 0, 8'hFF);
        tag = "R1";
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] ac = 3'($urandom);
            logic [47:0] dd = {16'($urandom), 32'($urandom)};
            bit re = ($urandom % 2) == 1;
            logic [7:0] aa = 8'($urandom % 9);
            bit rn = (n == 2000) ? 0 : 1;
            if (n == 2000) tag = "R10";
            if (n == 2001) tag = "R1";
            cyc(rn, ac, dd, re, aa);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule